// File: doc/BRIEF.md
# Folded Symmetric Substitution Score Memory

This block holds a table of signed substitution scores for a 20-letter alphabet and returns the score for any pair of letter codes. A symmetric 20-by-20 table would take 1024 words if the two 5-bit codes were simply joined into an address. Here the pair is folded into a 336-word space instead. The fold splits the table by the top bit of each code into four regions. The two mirrored off-diagonal regions land on one shared storage area, and the other two regions keep one word per ordered pair.

A host loads the table through a write port. The host gives two letter codes and a score, and the write goes through the same fold as the read. A lookup port takes two codes and presents the score one clock later. Codes above 0x13 are illegal: a write that uses one is dropped, and a read that uses one returns zero.

Top module: `subst_fold_mem`

## Requirements
- R1: When both codes are below 0x10, the word address is {0, first[3:0], second[3:0]}, so every ordered pair has its own word and (a,b) and (b,a) are separate entries.
- R2: When exactly one code is 0x10 or above, the pair folds to {3'b100, high[1:0], low[3:0]}, where high is the code with its MSB set, so (a,b) and (b,a) share one word and a write through either order is read back through both.
- R3: When both codes are 0x10 or above, the address is {5'b10100, first[1:0], second[1:0]}, giving 16 separate ordered entries.
- R4: Every legal pair maps inside words 0 to 335 (0x000 to 0x14F), and no two pairs that should be distinct share a word.
- R5: A read issued with rd_en high on a clock edge shows its score on rd_score after that edge. While rd_en is low, rd_score holds its value.
- R6: A write with wr_en high stores the score at the folded address on that edge. A read of the same word on the same edge returns the word's previous value.
- R7: Scores are 9-bit two's complement and are kept in the range -255 to +255. A write of -256 (9'h100) stores -255 (9'h101).
- R8: A code above 0x13 is illegal. A write that uses one leaves the memory unchanged, and a read that uses one returns 0.
- R9: While rst_n is low, rd_score is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| rd_en | input | 1 | Lookup strobe |
| rd_a | input | 5 | First letter code of the lookup |
| rd_b | input | 5 | Second letter code of the lookup |
| rd_score | output | 9 | Signed score, valid one cycle after the strobe |
| wr_en | input | 1 | Host write strobe |
| wr_a | input | 5 | First letter code of the write |
| wr_b | input | 5 | Second letter code of the write |
| wr_data | input | 9 | Signed score to store |

## Verification
Several properties are checked by assertions on every cycle:
- every folded address stays below 336;
- swapped mixed-region codes produce one address;
- distinct low-region pairs produce distinct addresses;
- the clamped write data is never -256;
- rd_score holds while idle;
- an illegal lookup yields zero.

Other behaviours need the bench's scenarios, because they depend on what was stored earlier. These are the absence of aliasing across all 400 ordered pairs, read-first behaviour on a collision, overwrite through the mirrored order, and the memory being left untouched by illegal writes.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int CODE_W  = 5;
  localparam int SCORE_W = 9;
  localparam int LETTERS = 20;
  localparam int DEPTH   = 336;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int HI_BIT  = CODE_W - 1;

  // Map a pair of letter codes onto the folded word address.
  function automatic logic [ADDR_W-1:0] fold_addr(input logic [CODE_W-1:0] ds,
                                                   input logic [CODE_W-1:0] dt);
    logic [ADDR_W-1:0] a;
    unique case ({ds[HI_BIT], dt[HI_BIT]})
      2'b00: a = {1'b0, ds[3:0], dt[3:0]};
      2'b01: a = {3'b100, dt[1:0], ds[3:0]};
      2'b10: a = {3'b100, ds[1:0], dt[3:0]};
      default: a = {5'b10100, ds[1:0], dt[1:0]};
    endcase
    return a;
  endfunction

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c < CODE_W'(LETTERS);
  endfunction

  // Keep stored scores symmetric about zero: the most negative code is pulled up by one.
  function automatic logic [SCORE_W-1:0] clamp_score(input logic [SCORE_W-1:0] x);
    if (x == {1'b1, {(SCORE_W-1){1'b0}}})
      return {1'b1, {(SCORE_W-2){1'b0}}, 1'b1};
    return x;
  endfunction
endpackage

// File: rtl/sfm_addr_fold.sv
module sfm_addr_fold
  import sfm_pkg::*;
(
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic [ADDR_W-1:0] addr,
  output logic              legal
);
  assign legal = code_ok(code_a) && code_ok(code_b);
  assign addr  = fold_addr(code_a, code_b);
endmodule

// File: rtl/sfm_score_ram.sv
module sfm_score_ram #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 336,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic             rlegal,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-first: the nonblocking write above lands after this sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rlegal ? mem[raddr] : '0;
  end

  p_waddr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < DEPTH));
  p_raddr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (re && rlegal) |-> (int'(raddr) < DEPTH));
endmodule

// File: rtl/subst_fold_mem.sv
module subst_fold_mem
  import sfm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [CODE_W-1:0]   rd_a,
  input  logic [CODE_W-1:0]   rd_b,
  output logic [SCORE_W-1:0]  rd_score,
  input  logic                wr_en,
  input  logic [CODE_W-1:0]   wr_a,
  input  logic [CODE_W-1:0]   wr_b,
  input  logic [SCORE_W-1:0]  wr_data
);
  logic [ADDR_W-1:0]  rd_addr, wr_addr;
  logic               rd_legal, wr_legal;
  logic               wr_fire;
  logic [SCORE_W-1:0] wr_clamped;

  sfm_addr_fold u_rd_fold (.code_a(rd_a), .code_b(rd_b), .addr(rd_addr), .legal(rd_legal));
  sfm_addr_fold u_wr_fold (.code_a(wr_a), .code_b(wr_b), .addr(wr_addr), .legal(wr_legal));

  assign wr_fire    = wr_en && wr_legal;
  assign wr_clamped = clamp_score(wr_data);

  sfm_score_ram #(.WIDTH(SCORE_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(wr_fire), .waddr(wr_addr), .wdata(wr_clamped),
    .re(rd_en), .rlegal(rd_legal), .raddr(rd_addr),
    .rdata(rd_score)
  );

  // R5: an idle lookup port keeps its last score
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_score));
  // R8: an illegal lookup yields zero
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_legal) |=> (rd_score == '0));
  // R7: the most negative code never reaches storage
  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_clamped != {1'b1, {(SCORE_W-1){1'b0}}}));
  // R2: swapped mixed-region codes share one word
  p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_legal && wr_legal && rd_a == wr_b && rd_b == wr_a &&
     rd_a[HI_BIT] != rd_b[HI_BIT]) |-> (rd_addr == wr_addr));
  // R1: distinct ordered low-region pairs never alias
  p_low_distinct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_legal && wr_legal && !rd_a[HI_BIT] && !rd_b[HI_BIT] &&
     !wr_a[HI_BIT] && !wr_b[HI_BIT] && {rd_a, rd_b} != {wr_a, wr_b})
    |-> (rd_addr != wr_addr));
endmodule

// File: tb/subst_fold_mem_test.sv
module subst_fold_mem_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0] rd_a = '0, rd_b = '0, wr_a = '0, wr_b = '0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_score;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  subst_fold_mem uut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_a(rd_a), .rd_b(rd_b),
    .rd_score(rd_score), .wr_en(wr_en), .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data));

  // Independent arithmetic view of the storage slot of an ordered pair.
  function automatic int slot(int a, int b);
    if (a < 16 && b < 16) return a * 16 + b;
    if (a >= 16 && b >= 16) return 320 + (a - 16) * 4 + (b - 16);
    if (a >= 16) return 256 + (a - 16) * 16 + b;
    return 256 + (b - 16) * 16 + a;
  endfunction

  function automatic logic [8:0] pattern(int a, int b);
    return 9'(slot(a, b) - 168);
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic do_write(int a, int b, logic [8:0] d);
    @(negedge clk); wr_en = 1; wr_a = 5'(a); wr_b = 5'(b); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read(int a, int b, output logic [8:0] v);
    @(negedge clk); rd_en = 1; rd_a = 5'(a); rd_b = 5'(b);
    @(negedge clk); rd_en = 0; v = rd_score;
  endtask

  task automatic t_reset_r9;
    chk("R9 reset score", rd_score, 9'd0);
  endtask

  task automatic t_sweep;
    logic [8:0] v;
    for (int a = 0; a < 20; a++)
      for (int b = 0; b < 20; b++) do_write(a, b, pattern(a, b));
    for (int a = 0; a < 20; a++)
      for (int b = 0; b < 20; b++) begin
        do_read(a, b, v);
        if (a < 16 && b < 16)        chk("R1 R4 low region", v, pattern(a, b));
        else if (a >= 16 && b >= 16) chk("R3 R4 high region", v, pattern(a, b));
        else                         chk("R2 R4 mixed region", v, pattern(a, b));
      end
  endtask

  task automatic t_mirror_r2;
    logic [8:0] v;
    do_write(8'h12, 8'h03, 9'd77);
    do_read(8'h03, 8'h12, v); chk("R2 mirrored read", v, 9'd77);
    do_write(8'h01, 8'h02, 9'd50);
    do_read(8'h02, 8'h01, v); chk("R1 swapped low pair untouched", v, pattern(2, 1));
    do_write(8'h11, 8'h13, 9'd33);
    do_read(8'h13, 8'h11, v); chk("R3 swapped high pair untouched", v, pattern(19, 17));
  endtask

  task automatic t_latency_hold_r5;
    logic [8:0] v;
    do_read(4, 4, v); chk("R5 score after one edge", v, pattern(4, 4));
    @(negedge clk); rd_a = 5'd5; rd_b = 5'd6;
    wr_en = 1; wr_a = 5'd4; wr_b = 5'd4; wr_data = 9'd99;
    @(negedge clk); wr_en = 0;
    repeat (2) @(negedge clk);
    chk("R5 hold while idle", rd_score, pattern(4, 4));
  endtask

  task automatic t_collision_r6;
    logic [8:0] v;
    @(negedge clk);
    wr_en = 1; wr_a = 5'd7; wr_b = 5'd9; wr_data = 9'h1F0;
    rd_en = 1; rd_a = 5'd7; rd_b = 5'd9;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R6 read-first on collision", rd_score, pattern(7, 9));
    do_read(7, 9, v); chk("R6 new value stored", v, 9'h1F0);
  endtask

  task automatic t_clamp_r7;
    logic [8:0] v;
    do_write(3, 3, 9'h100);
    do_read(3, 3, v); chk("R7 -256 stored as -255", v, 9'h101);
    do_write(3, 3, 9'h0FF);
    do_read(3, 3, v); chk("R7 +255 kept", v, 9'h0FF);
  endtask

  task automatic t_illegal_r8;
    logic [8:0] v;
    do_write(8'h14, 8'h00, 9'd1);
    do_read(8'h10, 8'h00, v); chk("R8 illegal write ignored (mixed)", v, pattern(16, 0));
    do_write(8'h1F, 8'h1F, 9'd2);
    do_read(8'h13, 8'h13, v); chk("R8 illegal write ignored (high)", v, pattern(19, 19));
    do_read(8'h17, 8'h02, v); chk("R8 illegal read is zero", v, 9'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r9();
    rst_n = 1;
    t_sweep();
    t_mirror_r2();
    t_latency_hold_r5();
    t_collision_r6();
    t_clamp_r7();
    t_illegal_r8();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule